// File: doc/BRIEF.md
# SAR ADC Serial Host Controller

This block drives a serial successive-approximation converter that starts a conversion on the rising edge of a dedicated start line and returns its result over a four-wire serial link. When the host asks for a sample, the controller raises the start line and counts out the worst-case conversion time. It then drops the line and runs a fixed number of serial clock pulses. Each pulse sends one configuration bit to the converter and brings back one result bit. The assembled result comes out with a one-cycle valid strobe. A flag beside it tells whether the word is two's complement or straight binary.

Two start-pulse styles are supported. In the short style the start line is high for only a few cycles, well inside the converter's 40 ns tolerance, so the converter stays powered. In the sleep style the line stays high through the whole conversion, so the converter powers down until the line falls. After each readout the controller keeps a minimum acquisition gap before it will raise the start line again.

Top module: `sar_adc_host`

## Requirements
- R1: While reset is asserted, the start line, serial clock, busy and result_valid are all low.
- R2: A start_req seen while idle sets the start line and busy high on the next clock edge. The configuration word and the mode are captured on that same edge.
- R3: In short-pulse mode (sleep_mode = 0), the start line is high for exactly PULSE_CYC cycles (8 ns by default). Any fall of the start line happens either within PULSE_CYC cycles of its rise or at least CONV_CYC cycles after it.
- R4: In sleep mode (sleep_mode = 1), the start line stays high for exactly CONV_CYC cycles (1.6 µs by default) and then falls.
- R5: No serial clock rising edge occurs while the start line is high, or earlier than CONV_CYC cycles after the start line rose.
- R6: Each readout makes exactly RES_W (12) serial clock pulses, and the clock idles low. The serial data output carries the captured cfg MSB first, one bit per rising edge; after the CFG_W (6) configuration bits it carries 0. It changes only while the serial clock is low.
- R7: result holds the RES_W bits read from the converter, MSB first. The first bit is sampled before the first rising clock edge, and each later bit is sampled just before the rising edge that follows the falling edge that shifted it out.
- R8: result_valid is a one-cycle pulse, given while busy is high. With it, result_signed equals the inverse of cfg bit UNI_POS (bit 2) as captured at the request: 1 means two's complement, 0 means straight binary.
- R9: The next start-line rise comes at least ACQ_CYC cycles (240 ns by default) after the last serial clock falling edge, even when start_req is held high continuously.
- R10: A start_req that arrives while busy is high does not start a conversion, either then or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request one conversion |
| sleep_mode | input | 1 | 1: hold start line high through the conversion; 0: short pulse |
| cfg | input | CFG_W | Configuration word sent to the converter, MSB first |
| busy | output | 1 | Conversion, readout or acquisition gap in progress |
| result | output | RES_W | Last conversion result |
| result_valid | output | 1 | One-cycle strobe when result updates |
| result_signed | output | 1 | 1 when result is two's complement |
| adc_conv | output | 1 | Conversion start line to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdi | output | 1 | Configuration data to the converter |
| adc_sdo | input | 1 | Result data from the converter |

## Verification
The bench pairs a model of the converter with conversions in both pulse styles. It uses result patterns of all ones, all zeros, a lone MSB, a lone LSB and an alternating mix. The lone-bit words show whether the first bit is sampled before the first clock edge and whether the bit order is right. The mixed words catch a bit that is sampled on the wrong clock edge. Configuration words that differ in the unipolar bit and in their end bits show the send order and the signed-flag mapping. A request held high across two conversions, and requests issued while busy, check the acquisition gap and that extra requests are ignored.

// File: rtl/sar_adc_host.sv
module sar_adc_host #(
  parameter int RES_W     = 12,
  parameter int CFG_W     = 6,
  parameter int UNI_POS   = 2,
  parameter int CONV_CYC  = 400,
  parameter int PULSE_CYC = 2,
  parameter int ACQ_CYC   = 60,
  parameter int SCK_HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             sleep_mode,
  input  logic [CFG_W-1:0] cfg,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             result_signed,
  output logic             adc_conv,
  output logic             adc_sck,
  output logic             adc_sdi,
  input  logic             adc_sdo
);
  localparam int CNT_MAX = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int DIV_W   = $clog2(SCK_HALF + 1);
  localparam int BIT_W   = $clog2(RES_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_XFER, S_DONE, S_ACQ} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [DIV_W-1:0]   div;
  logic [BIT_W-1:0]   bitn;
  logic [CFG_W-1:0]   cfg_sr;
  logic [RES_W-1:0]   res_sr;
  logic               sleep_q;
  logic               uni_q;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      cnt           <= '0;
      div           <= '0;
      bitn          <= '0;
      cfg_sr        <= '0;
      res_sr        <= '0;
      sleep_q       <= 1'b0;
      uni_q         <= 1'b0;
      result        <= '0;
      result_valid  <= 1'b0;
      result_signed <= 1'b0;
      adc_conv      <= 1'b0;
      adc_sck       <= 1'b0;
      adc_sdi       <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      case (state)
        S_IDLE: if (start_req) begin
          state    <= S_CONV;
          adc_conv <= 1'b1;
          cnt      <= '0;
          sleep_q  <= sleep_mode;
          uni_q    <= cfg[UNI_POS];
          cfg_sr   <= cfg;
        end
        S_CONV: begin
          cnt <= cnt + 1'b1;
          if (!sleep_q && cnt == CNT_W'(PULSE_CYC - 1))
            adc_conv <= 1'b0;
          if (cnt == CNT_W'(CONV_CYC - 1)) begin
            adc_conv <= 1'b0;
            state    <= S_XFER;
            div      <= '0;
            bitn     <= '0;
            adc_sdi  <= cfg_sr[CFG_W-1];
            cfg_sr   <= cfg_sr << 1;
          end
        end
        S_XFER: begin
          div <= div + 1'b1;
          if (div == DIV_W'(SCK_HALF - 1)) begin
            div <= '0;
            if (!adc_sck) begin
              adc_sck <= 1'b1;
              res_sr  <= {res_sr[RES_W-2:0], adc_sdo};
            end else begin
              adc_sck <= 1'b0;
              bitn    <= bitn + 1'b1;
              adc_sdi <= cfg_sr[CFG_W-1];
              cfg_sr  <= cfg_sr << 1;
              if (bitn == BIT_W'(RES_W - 1))
                state <= S_DONE;
            end
          end
        end
        S_DONE: begin
          result        <= res_sr;
          result_valid  <= 1'b1;
          result_signed <= ~uni_q;
          cnt           <= '0;
          state         <= S_ACQ;
        end
        S_ACQ: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(ACQ_CYC - 1))
            state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_host_chk.sv
module sar_adc_host_chk #(
  parameter int CONV_CYC  = 400,
  parameter int PULSE_CYC = 2,
  parameter int ACQ_CYC   = 60
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic result_valid,
  input logic adc_conv,
  input logic adc_sck,
  input logic adc_sdi
);
  logic [15:0] hi_cnt;
  logic [15:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      gap_cnt <= 16'(ACQ_CYC);
    end else begin
      if (!adc_conv) hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      if (adc_sck) gap_cnt <= '0;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!adc_conv && !adc_sck && !busy && !result_valid));

  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> (busy && !$past(busy)));

  // R3, R4
  conv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv) |-> (hi_cnt == 16'(PULSE_CYC) || hi_cnt == 16'(CONV_CYC)));

  // R5
  sck_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sck) |-> !adc_conv);

  // R6
  sdi_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_sdi) |-> !adc_sck);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (busy ##1 !result_valid));

  // R9
  acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> gap_cnt >= 16'(ACQ_CYC));
endmodule

bind sar_adc_host sar_adc_host_chk #(
  .CONV_CYC(CONV_CYC), .PULSE_CYC(PULSE_CYC), .ACQ_CYC(ACQ_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .result_valid(result_valid),
  .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdi(adc_sdi)
);

// File: tb/sim_sar_adc_host.sv
`timescale 1ns/1ps
module sim_sar_adc_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic        sleep_mode = 1'b0;
  logic [5:0]  cfg = '0;
  logic        busy;
  logic [11:0] result;
  logic        result_valid;
  logic        result_signed;
  logic        adc_conv, adc_sck, adc_sdi, adc_sdo;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sar_adc_host u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .sleep_mode(sleep_mode),
    .cfg(cfg), .busy(busy), .result(result), .result_valid(result_valid),
    .result_signed(result_signed), .adc_conv(adc_conv), .adc_sck(adc_sck),
    .adc_sdi(adc_sdi), .adc_sdo(adc_sdo)
  );

  // converter model
  logic [11:0] adc_word = '0;
  logic [5:0]  rx = '0;
  int    k = -1;
  int    nrise = 0;
  int    rises = 0;
  int    early_bad = 0, tail_bad = 0, win_bad = 0;
  realtime t_rise = 0, t_fall_sck = 0, hi_ns = 0, gap_ns = 1.0e9;
  bit    have_fall = 0;

  assign adc_sdo = (k >= 0 && k < 12) ? adc_word[k] : 1'b0;

  always @(posedge adc_conv) begin
    t_rise = $realtime; k = 11; nrise = 0; rises++;
    if (have_fall) gap_ns = $realtime - t_fall_sck;
  end
  always @(negedge adc_conv) begin
    hi_ns = $realtime - t_rise;
    if (hi_ns > 40.0 && hi_ns < 1600.0) win_bad++;
  end
  always @(posedge adc_sck) begin
    if (adc_conv || ($realtime - t_rise) < 1600.0) early_bad++;
    if (nrise < 6) rx = {rx[4:0], adc_sdi};
    else if (adc_sdi) tail_bad++;
    nrise++;
  end
  always @(negedge adc_sck) begin
    k = k - 1; t_fall_sck = $realtime; have_fall = 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (result_valid) begin got = 1; break; end
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!adc_conv, "R1", "conv in reset", adc_conv, 0);
    chk(!adc_sck, "R1", "sck in reset", adc_sck, 0);
    chk(!busy, "R1", "busy in reset", busy, 0);
    chk(!result_valid, "R1", "valid in reset", result_valid, 0);
  endtask

  task automatic run_conv(input bit mode, input logic [5:0] c, input logic [11:0] w);
    bit got;
    while (busy) @(negedge clk);
    adc_word = w; cfg = c; sleep_mode = mode;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    cfg = ~c; sleep_mode = ~mode;
    chk(adc_conv && busy, "R2", "conv/busy after request", {adc_conv, busy}, 3);
    wait_valid(got);
    chk(got, "R8", "valid seen", got, 1);
    chk(result == w, "R7", "result word", result, w);
    chk(result_signed == ~c[2], "R8", "signed flag", result_signed, ~c[2]);
    chk(rx == c, "R6", "cfg bits received", rx, c);
    chk(nrise == 12, "R6", "sck pulse count", nrise, 12);
    if (mode) chk(hi_ns == 1600.0, "R4", "sleep pulse ns", longint'(hi_ns), 1600);
    else      chk(hi_ns == 8.0, "R3", "short pulse ns", longint'(hi_ns), 8);
    @(negedge clk);
    chk(!result_valid, "R8", "valid one cycle", result_valid, 0);
    chk(result == w, "R7", "result held", result, w);
  endtask

  task automatic test_ignore();
    int r0;
    bit got;
    while (busy) @(negedge clk);
    r0 = rises;
    adc_word = 12'h5A3; cfg = 6'b101101; sleep_mode = 1'b0;
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    repeat (20) @(negedge clk);
    start_req = 1'b1; repeat (5) @(negedge clk); start_req = 1'b0;
    wait_valid(got);
    chk(result == 12'h5A3, "R10", "result after extra requests", result, 12'h5A3);
    repeat (150) @(negedge clk);
    chk(rises == r0 + 1, "R10", "start edges", rises, r0 + 1);
    chk(!busy, "R10", "idle afterwards", busy, 0);
  endtask

  task automatic test_back_to_back();
    int r0;
    bit got;
    while (busy) @(negedge clk);
    r0 = rises;
    adc_word = 12'h3C7; cfg = 6'b000100; sleep_mode = 1'b1;
    start_req = 1'b1;
    wait_valid(got);
    chk(result == 12'h3C7, "R9", "first result", result, 12'h3C7);
    adc_word = 12'hC38;
    wait_valid(got);
    start_req = 1'b0;
    chk(result == 12'hC38, "R9", "second result", result, 12'hC38);
    chk(rises == r0 + 2, "R9", "two starts", rises, r0 + 2);
    chk(gap_ns >= 240.0, "R9", "acquisition gap ns", longint'(gap_ns), 240);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_conv(1'b0, 6'b100000, 12'h800);
    run_conv(1'b1, 6'b000001, 12'h001);
    run_conv(1'b0, 6'b111111, 12'hFFF);
    run_conv(1'b1, 6'b011010, 12'h000);
    run_conv(1'b0, 6'b110011, 12'hA5C);
    run_conv(1'b1, 6'b101100, 12'h6B9);
    test_ignore();
    test_back_to_back();
    repeat (100) @(negedge clk);
    chk(early_bad == 0, "R5", "early sck edges", early_bad, 0);
    chk(tail_bad == 0, "R6", "nonzero tail bits", tail_bad, 0);
    chk(win_bad == 0, "R3", "start fall in forbidden window", win_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule